// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This unit resolves the conditional branch class of an 8-bit processor. When the start strobe is high, it looks at the opcode byte and decides whether the opcode is one of the eight flag-tested branches. If it is, the unit compares the selected status flag with the polarity the opcode asks for. It then produces the address of the next instruction and the number of cycles the instruction costs. A taken branch adds a sign-extended 8-bit displacement to the address of the instruction that follows the branch.

All results are registered. They appear one clock after the strobe, together with a one-cycle `done` pulse, and they hold until the next strobe. A separate self-loop flag reports a taken branch whose target is the branch itself. A surrounding sequencer can use it to detect an idle spin. The unit has no flag outputs, so it cannot change the processor status.

Top module: `br_unit`

## Requirements
- R1: An opcode is recognised as a branch exactly when its low five bits equal 0x10. This gives the eight codes 0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0 and 0xF0.
- R2: For a recognised branch, opcode bits 7:6 select the flag: 00 selects N, 01 selects V, 10 selects C and 11 selects Z. Opcode bit 5 gives the flag value that makes the branch taken. `taken` is 1 exactly when the selected flag equals bit 5.
- R3: When a branch is taken, `next_pc` equals `follow_pc` plus the sign-extended `disp`, modulo 65536.
- R4: When a recognised branch is not taken, `next_pc` equals `follow_pc` and `cycles` equals 2.
- R5: When a branch is taken, `cycles` is 3 if the high byte of the target equals the high byte of `follow_pc`, and 4 if the two high bytes differ.
- R6: `self_loop` is 1 exactly when the branch is taken and `disp` is 0xFE.
- R7: For an opcode that is not a branch, the outputs are as follows: `recognised` is 0, `taken` is 0, `self_loop` is 0, `next_pc` equals `follow_pc`, and `cycles` is 0.
- R8: When `start` is high at a clock edge, the inputs are captured at that edge. The results and a `done` pulse appear after that edge. `done` stays high for one cycle only, unless `start` is high again. While `start` is low, the outputs hold their values.
- R9: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture strobe for the current instruction |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Signed branch displacement |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| follow_pc | input | 16 | Address of the instruction after the branch |
| done | output | 1 | One-cycle result-valid pulse |
| recognised | output | 1 | Opcode is a conditional branch |
| taken | output | 1 | Branch condition met |
| next_pc | output | 16 | Resolved next instruction address |
| cycles | output | 3 | Cycle cost of the instruction |
| self_loop | output | 1 | Taken branch whose target is itself |

## Verification
On every cycle, the bound checker checks the following:
- how `done` follows the strobe;
- that outputs hold between strobes;
- that recognition follows the opcode bit pattern;
- that a branch that is not taken, or an opcode that is not a branch, passes `follow_pc` through;
- that the cycle cost stays consistent with `taken` and with whether the page was crossed;
- that `self_loop` implies a taken branch with displacement 0xFE.

The exact target arithmetic, such as wrap-around across 0x0000 and 0xFFFF and negative displacements that cross a page, is shown only by the bench's vectors. The same holds for the mapping of each flag and polarity to each of the eight opcodes.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int OPC_W   = 8;
    localparam int MATCH_W = 5;
    localparam logic [MATCH_W-1:0] BR_MATCH = 5'h10;

    typedef enum logic [1:0] {
        SEL_NEG   = 2'b00,
        SEL_OVF   = 2'b01,
        SEL_CARRY = 2'b10,
        SEL_ZERO  = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic      is_branch;
        flag_sel_e sel;
        logic      want;
    } br_decode_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } br_flags_t;

    function automatic br_decode_t decode_opcode(input logic [OPC_W-1:0] op);
        br_decode_t d;
        d.is_branch = (op[MATCH_W-1:0] == BR_MATCH);
        d.sel       = flag_sel_e'(op[7:6]);
        d.want      = op[5];
        return d;
    endfunction

    function automatic logic pick_flag(input br_flags_t f, input flag_sel_e s);
        logic v;
        unique case (s)
            SEL_NEG:   v = f.neg;
            SEL_OVF:   v = f.ovf;
            SEL_CARRY: v = f.carry;
            default:   v = f.zero;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output br_decode_t       dec
);
    always_comb dec = decode_opcode(opcode);
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
(
    input  br_decode_t dec,
    input  br_flags_t  flags,
    output logic       taken
);
    logic flag_val;
    always_comb begin
        flag_val = pick_flag(flags, dec.sel);
        taken    = dec.is_branch && (flag_val == dec.want);
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 8,
    parameter int CYC_W   = 3,
    parameter int BASE_CY = 2,
    parameter int PAGE_W  = 8
) (
    input  logic              is_branch,
    input  logic              taken,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] follow_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic [CYC_W-1:0]  cycles,
    output logic              self_loop
);
    localparam int EXT_W = ADDR_W - DISP_W;
    localparam int HI_LO = PAGE_W;
    localparam logic [DISP_W-1:0] LOOP_DISP = {{(DISP_W-1){1'b1}}, 1'b0};
    localparam logic [CYC_W-1:0]  CY_NT   = CYC_W'(BASE_CY);
    localparam logic [CYC_W-1:0]  CY_SAME = CYC_W'(BASE_CY + 1);
    localparam logic [CYC_W-1:0]  CY_XPG  = CYC_W'(BASE_CY + 2);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] target;
    logic              crossed;

    always_comb begin
        offset  = {{EXT_W{disp[DISP_W-1]}}, disp};
        target  = follow_pc + offset;
        crossed = (target[ADDR_W-1:HI_LO] != follow_pc[ADDR_W-1:HI_LO]);

        next_pc   = taken ? target : follow_pc;
        self_loop = taken && (disp == LOOP_DISP);

        if (!is_branch)
            cycles = '0;
        else if (!taken)
            cycles = CY_NT;
        else if (crossed)
            cycles = CY_XPG;
        else
            cycles = CY_SAME;
    end
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int CYC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    input  logic [ADDR_W-1:0] follow_pc,
    output logic              done,
    output logic              recognised,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [CYC_W-1:0]  cycles,
    output logic              self_loop
);
    br_decode_t        dec;
    br_flags_t         flags;
    logic              taken_c;
    logic [ADDR_W-1:0] npc_c;
    logic [CYC_W-1:0]  cyc_c;
    logic              loop_c;

    always_comb begin
        flags.neg   = flag_n;
        flags.zero  = flag_z;
        flags.carry = flag_c;
        flags.ovf   = flag_v;
    end

    br_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    br_cond u_cond (
        .dec   (dec),
        .flags (flags),
        .taken (taken_c)
    );

    br_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .CYC_W  (CYC_W)
    ) u_tgt (
        .is_branch (dec.is_branch),
        .taken     (taken_c),
        .disp      (disp),
        .follow_pc (follow_pc),
        .next_pc   (npc_c),
        .cycles    (cyc_c),
        .self_loop (loop_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            recognised <= 1'b0;
            taken      <= 1'b0;
            next_pc    <= '0;
            cycles     <= '0;
            self_loop  <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                recognised <= dec.is_branch;
                taken      <= taken_c;
                next_pc    <= npc_c;
                cycles     <= cyc_c;
                self_loop  <= loop_c;
            end
        end
    end
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [7:0]        opcode,
    input logic [DISP_W-1:0] disp,
    input logic [ADDR_W-1:0] follow_pc,
    input logic              done,
    input logic              recognised,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic [CYC_W-1:0]  cycles,
    input logic              self_loop
);
    localparam logic [DISP_W-1:0] LOOP_D = {{(DISP_W-1){1'b1}}, 1'b0};

    // R8
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)));

    // R1
    recog_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (recognised == ($past(opcode[4:0]) == 5'h10)));

    // R7
    nonbranch_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !recognised) |-> (!taken && !self_loop && cycles == '0));

    // R4
    pass_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !$isunknown(follow_pc)) |=> (taken || next_pc == $past(follow_pc)));

    // R5
    taken_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (done && taken) |-> (cycles == CYC_W'(3) || cycles == CYC_W'(4)));

    // R4
    nt_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (done && recognised && !taken) |-> (cycles == CYC_W'(2)));

    // R5
    same_page_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!(taken && cycles == CYC_W'(3)) ||
                   next_pc[ADDR_W-1:8] == $past(follow_pc[ADDR_W-1:8])));

    // R6
    loop_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!self_loop || (taken && $past(disp) == LOOP_D)));
endmodule

bind br_unit br_unit_chk #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .CYC_W  (CYC_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opcode     (opcode),
    .disp       (disp),
    .follow_pc  (follow_pc),
    .done       (done),
    .recognised (recognised),
    .taken      (taken),
    .next_pc    (next_pc),
    .cycles     (cycles),
    .self_loop  (self_loop)
);

// File: tb/br_unit_tb.sv
module br_unit_tb_top;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  d;
        logic [3:0]  nzcv;
        logic [15:0] pc;
        logic        e_rec;
        logic        e_tk;
        logic [15:0] e_pc;
        logic [2:0]  e_cy;
        logic        e_loop;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 8'h05, 4'b0000, 16'h1000, 1'b1, 1'b1, 16'h1005, 3'd3, 1'b0},
        '{8'h10, 8'h05, 4'b1000, 16'h1000, 1'b1, 1'b0, 16'h1000, 3'd2, 1'b0},
        '{8'h30, 8'h10, 4'b1000, 16'h2000, 1'b1, 1'b1, 16'h2010, 3'd3, 1'b0},
        '{8'h50, 8'h80, 4'b1110, 16'h3050, 1'b1, 1'b1, 16'h2FD0, 3'd4, 1'b0},
        '{8'h70, 8'h80, 4'b1110, 16'h3050, 1'b1, 1'b0, 16'h3050, 3'd2, 1'b0},
        '{8'h90, 8'h7F, 4'b1101, 16'h40F0, 1'b1, 1'b1, 16'h416F, 3'd4, 1'b0},
        '{8'hB0, 8'hFE, 4'b0010, 16'h5002, 1'b1, 1'b1, 16'h5000, 3'd3, 1'b1},
        '{8'hD0, 8'h01, 4'b1011, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 3'd4, 1'b0},
        '{8'hF0, 8'hF0, 4'b0100, 16'h0005, 1'b1, 1'b1, 16'hFFF5, 3'd4, 1'b0},
        '{8'hF0, 8'hF0, 4'b1011, 16'h0005, 1'b1, 1'b0, 16'h0005, 3'd2, 1'b0},
        '{8'hB0, 8'hFE, 4'b1101, 16'h5002, 1'b1, 1'b0, 16'h5002, 3'd2, 1'b0},
        '{8'hA9, 8'hFE, 4'b1111, 16'h1234, 1'b0, 1'b0, 16'h1234, 3'd0, 1'b0},
        '{8'h18, 8'h05, 4'b0000, 16'h4321, 1'b0, 1'b0, 16'h4321, 3'd0, 1'b0},
        '{8'hD0, 8'hFE, 4'b0000, 16'h0100, 1'b1, 1'b1, 16'h00FE, 3'd4, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic [15:0] follow_pc = '0;
    logic        done, recognised, taken, self_loop;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    br_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .disp(disp),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .follow_pc(follow_pc), .done(done), .recognised(recognised),
        .taken(taken), .next_pc(next_pc), .cycles(cycles), .self_loop(self_loop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        opcode    = v.op;
        disp      = v.d;
        {flag_n, flag_z, flag_c, flag_v} = v.nzcv;
        follow_pc = v.pc;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 done", 32'(done), 0);
        check("R9 next_pc", 32'(next_pc), 0);
        check("R9 cycles", 32'(cycles), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i]);
            check("R8 done", 32'(done), 1);
            check("R1 recognised", 32'(recognised), 32'(VECS[i].e_rec));
            check("R2 taken", 32'(taken), 32'(VECS[i].e_tk));
            check("R3 next_pc", 32'(next_pc), 32'(VECS[i].e_pc));
            check("R5 cycles", 32'(cycles), 32'(VECS[i].e_cy));
            check("R6 self_loop", 32'(self_loop), 32'(VECS[i].e_loop));
        end

        // R8: done lasts one cycle and outputs hold while start is low
        @(negedge clk);
        opcode = 8'h10; disp = 8'h40; follow_pc = 16'h7777;
        check("R8 done low", 32'(done), 0);
        @(negedge clk);
        check("R8 hold next_pc", 32'(next_pc), 32'h00FE);
        check("R8 hold cycles", 32'(cycles), 4);

        // R7: non-branch with taken-looking flags
        issue('{8'hB1, 8'h10, 4'b1111, 16'hABCD, 1'b0, 1'b0, 16'hABCD, 3'd0, 1'b0});
        check("R7 recognised", 32'(recognised), 0);
        check("R7 taken", 32'(taken), 0);
        check("R7 next_pc", 32'(next_pc), 32'hABCD);

        // R9: reset mid-run after a taken branch
        issue(VECS[0]);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 taken cleared", 32'(taken), 0);
        check("R9 next_pc cleared", 32'(next_pc), 0);
        check("R9 recognised cleared", 32'(recognised), 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule